// File: doc/BRIEF.md
# Multichannel ADC Sample Sequencer

The sequencer controls a successive-approximation converter core. It walks a programmed list of input channels. For each list slot it waits a settle interval, then asks the converter for one conversion on that slot's channel. It waits for the result and stores it in a result queue, together with the channel number. Software starts the sequence with a start pulse while the engine is enabled. The sequence runs once through the list, or wraps around the list without end in continuous mode. A stop pulse ends the sequence early, and enable should be removed only once the engine reports idle.

The converter core is modelled as a simple handshake. The block drives a one-cycle request with a channel number, and the core later returns a valid strobe with a sample. Averaging and delta logic live in separate blocks. Their busy flags enter here only so that they can be merged into the busy status. The result queue is read one entry per read strobe. It reports its fill level, full and empty flags and a sticky overflow flag, and it raises an interrupt once the fill level reaches a programmed threshold.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block has no request outstanding. The queue is empty, level_o is 0, full_o is 0 and empty_o is 1. Overflow, interrupt and sample busy are all low.
- R2: A start pulse with en_i high while the block is idle sets busy_o[0] on the next cycle. A start with en_i low, or a start while a sequence runs, has no effect.
- R3: conv_req_o is a single-cycle pulse. It rises D = (dly_cnt_i+1)·4^dly_tb_i cycles after the edge that accepted start, or D cycles after the edge that accepted the previous result.
- R4: For list slot i, conv_chan_o equals list_i[3i+2:3i]. Slots 0 to max_idx_i are used in ascending order, so max_idx_i = 0 uses one slot.
- R5: Without cont_i the block goes idle after the result of slot max_idx_i. With cont_i it wraps back to slot 0 and keeps running.
- R6: A queue entry holds the channel in bits 14:12 and the sample in bits 11:0. When wide_i is 0, sample bits 11:10 are forced to 0.
- R7: rd_data_o shows the oldest entry, and rd_i removes it. With the queue empty, rd_data_o reads 0 and rd_i is ignored. The queue holds 32 entries. level_o is the 5-bit fill level, which reads 0 when the queue is full. full_o and empty_o flag the two ends.
- R8: A result that arrives while the queue is full is dropped, even if a read happens in the same cycle. It sets overflow_o, which then stays high until reset.
- R9: irq_o is high exactly when irq_en_i is high and the fill level (0 to 32) is at least irq_thr_i.
- R10: A stop during the settle interval returns the block to idle on the next cycle, and no request is issued. A stop while a conversion is outstanding lets that result be stored, and the block then goes idle.
- R11: busy_o is {delta_busy_i, avg_busy_i, sample busy}, and idle_o is high only when all three bits are low.
- R12: conv_valid_i is ignored when no conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| cont_i | input | 1 | Continuous mode |
| list_i | input | 24 | Channel list, 3 bits per slot |
| max_idx_i | input | 3 | Last slot used |
| dly_cnt_i | input | 8 | Settle count |
| dly_tb_i | input | 2 | Settle timebase select (tick = 4^sel cycles) |
| wide_i | input | 1 | 1: 12-bit samples, 0: 10-bit samples |
| irq_en_i | input | 1 | Interrupt enable |
| irq_thr_i | input | 5 | Interrupt fill threshold |
| avg_busy_i | input | 1 | Averaging block busy |
| delta_busy_i | input | 1 | Delta block busy |
| conv_req_o | output | 1 | Conversion request pulse |
| conv_chan_o | output | 3 | Channel for the conversion |
| conv_valid_i | input | 1 | Conversion result strobe |
| conv_data_i | input | 12 | Conversion result |
| rd_i | input | 1 | Queue read strobe |
| rd_data_o | output | 15 | Oldest queue entry |
| level_o | output | 5 | Queue fill level |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |
| overflow_o | output | 1 | Sticky overflow flag |
| busy_o | output | 3 | Busy vector |
| idle_o | output | 1 | All busy flags clear |
| irq_o | output | 1 | Fill threshold interrupt |

## Verification
The assertions assume that list_i, max_idx_i, the settle fields and wide_i stay constant while a sequence runs. They also assume that en_i drops only when the block is idle and that the converter answers each request exactly once, after the request cycle. The stimulus changes configuration only between sequences and keeps en_i high while a sequence runs. Its converter model returns one result per observed request, after a latency of at least one cycle. The one deliberate valid outside a conversion is a stray strobe sent while the block is idle, which R12 covers.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SETTLE = 2'd1,
    S_REQ    = 2'd2,
    S_WAIT   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 8,
  parameter int TB_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [TB_W-1:0]  tb_i,
  output logic             done_o
);
  localparam int PRE_W = 2 * ((1 << TB_W) - 1);

  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [CNT_W-1:0] tick_q;
  logic             at_lim;

  // tick period is 4^tb cycles
  assign pre_lim = ~({PRE_W{1'b1}} << (2 * tb_i));
  assign at_lim  = (pre_q == pre_lim);
  assign done_o  = run_i && at_lim && (tick_q == cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (!run_i) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (at_lim) begin
      pre_q  <= '0;
      tick_q <= tick_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  assert_done_needs_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (pre_q == '0) && (tick_q == '0));
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 15,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [AW:0]   cnt_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          ovf_q, do_push, do_pop;

  assign full_o  = (cnt_q == DEPTH[AW:0]);
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign ovf_o   = ovf_q;
  // full check uses the pre-pop count: a push to a full queue drops
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = empty_o ? '0 : mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && full_o) ovf_q <= 1'b1;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i) |=> ovf_o);
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  assert_pop_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_ENT    = 8,
  parameter int CH_W     = 3,
  parameter int SMP_W    = 12,
  parameter int NARROW_W = 10,
  localparam int IDX_W   = $clog2(N_ENT),
  localparam int ENT_W   = CH_W + SMP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  cont_i,
  input  logic [N_ENT*CH_W-1:0] list_i,
  input  logic [IDX_W-1:0]      max_idx_i,
  input  logic                  wide_i,
  input  logic                  dly_done_i,
  input  logic                  conv_valid_i,
  input  logic [SMP_W-1:0]      conv_data_i,
  output logic                  dly_run_o,
  output logic                  conv_req_o,
  output logic [CH_W-1:0]       conv_chan_o,
  output logic                  push_o,
  output logic [ENT_W-1:0]      push_data_o,
  output logic                  busy_o
);
  localparam logic [SMP_W-1:0] NARROW_MASK =
    {{(SMP_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  seq_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             stop_pend_q, last_slot;
  logic [SMP_W-1:0] smp;

  assign conv_chan_o = list_i[idx_q*CH_W +: CH_W];
  assign conv_req_o  = (st_q == S_REQ);
  assign dly_run_o   = (st_q == S_SETTLE);
  assign busy_o      = (st_q != S_IDLE);
  assign last_slot   = (idx_q == max_idx_i);
  assign smp         = wide_i ? conv_data_i : (conv_data_i & NARROW_MASK);
  assign push_o      = (st_q == S_WAIT) && conv_valid_i;
  assign push_data_o = {conv_chan_o, smp};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      idx_q       <= '0;
      stop_pend_q <= 1'b0;
    end else if (!en_i) begin
      st_q        <= S_IDLE;
      stop_pend_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q        <= S_SETTLE;
          idx_q       <= '0;
          stop_pend_q <= 1'b0;
        end
        S_SETTLE: begin
          if (stop_i)          st_q <= S_IDLE;
          else if (dly_done_i) st_q <= S_REQ;
        end
        S_REQ: begin
          if (stop_i) stop_pend_q <= 1'b1;
          st_q <= S_WAIT;
        end
        S_WAIT: begin
          if (conv_valid_i) begin
            if (stop_pend_q || stop_i || (last_slot && !cont_i)) begin
              st_q        <= S_IDLE;
              stop_pend_q <= 1'b0;
            end else begin
              idx_q <= last_slot ? '0 : idx_q + 1'b1;
              st_q  <= S_SETTLE;
            end
          end else if (stop_i) begin
            stop_pend_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_busy_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && en_i && !busy_o) |=> busy_o);
  assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
  assert_stop_settle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_run_o && stop_i) |=> !busy_o);
  assert_valid_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_valid_i && !busy_o) |-> !push_o);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int N_ENT    = 8,
  parameter int CH_W     = 3,
  parameter int SMP_W    = 12,
  parameter int NARROW_W = 10,
  parameter int DEPTH    = 32,
  parameter int DLY_W    = 8,
  parameter int TB_W     = 2,
  localparam int IDX_W   = $clog2(N_ENT),
  localparam int AW      = $clog2(DEPTH),
  localparam int ENT_W   = CH_W + SMP_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  cont_i,
  input  logic [N_ENT*CH_W-1:0] list_i,
  input  logic [IDX_W-1:0]      max_idx_i,
  input  logic [DLY_W-1:0]      dly_cnt_i,
  input  logic [TB_W-1:0]       dly_tb_i,
  input  logic                  wide_i,
  input  logic                  irq_en_i,
  input  logic [AW-1:0]         irq_thr_i,
  input  logic                  avg_busy_i,
  input  logic                  delta_busy_i,
  output logic                  conv_req_o,
  output logic [CH_W-1:0]       conv_chan_o,
  input  logic                  conv_valid_i,
  input  logic [SMP_W-1:0]      conv_data_i,
  input  logic                  rd_i,
  output logic [ENT_W-1:0]      rd_data_o,
  output logic [AW-1:0]         level_o,
  output logic                  full_o,
  output logic                  empty_o,
  output logic                  overflow_o,
  output logic [2:0]            busy_o,
  output logic                  idle_o,
  output logic                  irq_o
);
  logic             dly_run, dly_done, push, smp_busy;
  logic [ENT_W-1:0] push_data;
  logic [AW:0]      fill;

  adc_seq_timer #(.CNT_W(DLY_W), .TB_W(TB_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (dly_run),
    .cnt_i  (dly_cnt_i),
    .tb_i   (dly_tb_i),
    .done_o (dly_done)
  );

  adc_seq_ctrl #(
    .N_ENT(N_ENT), .CH_W(CH_W), .SMP_W(SMP_W), .NARROW_W(NARROW_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .cont_i       (cont_i),
    .list_i       (list_i),
    .max_idx_i    (max_idx_i),
    .wide_i       (wide_i),
    .dly_done_i   (dly_done),
    .conv_valid_i (conv_valid_i),
    .conv_data_i  (conv_data_i),
    .dly_run_o    (dly_run),
    .conv_req_o   (conv_req_o),
    .conv_chan_o  (conv_chan_o),
    .push_o       (push),
    .push_data_o  (push_data),
    .busy_o       (smp_busy)
  );

  adc_seq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (push_data),
    .pop_i   (rd_i),
    .data_o  (rd_data_o),
    .cnt_o   (fill),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (overflow_o)
  );

  assign level_o = fill[AW-1:0];
  assign busy_o  = {delta_busy_i, avg_busy_i, smp_busy};
  assign idle_o  = ~|busy_o;
  assign irq_o   = irq_en_i && (fill >= {1'b0, irq_thr_i});

  assert_irq_off_when_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
  assert_req_only_when_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> !idle_o);
endmodule

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 0, start = 0, stop = 0, cont = 0, wide = 1, irq_en = 0;
  logic [23:0] list = '0;
  logic [2:0]  max_idx = '0;
  logic [7:0]  dcnt = '0;
  logic [1:0]  dtb = '0;
  logic [4:0]  thr = '0;
  logic        abusy = 0, dbusy = 0, cvalid = 0, rd = 0;
  logic [11:0] cdata = '0;
  logic        req, full, empty, ovf, idle, irq;
  logic [2:0]  chan, busy;
  logic [14:0] rdata;
  logic [4:0]  level;

  always #10 clk = ~clk;

  adc_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .stop_i(stop),
    .cont_i(cont), .list_i(list), .max_idx_i(max_idx), .dly_cnt_i(dcnt),
    .dly_tb_i(dtb), .wide_i(wide), .irq_en_i(irq_en), .irq_thr_i(thr),
    .avg_busy_i(abusy), .delta_busy_i(dbusy), .conv_req_o(req),
    .conv_chan_o(chan), .conv_valid_i(cvalid), .conv_data_i(cdata),
    .rd_i(rd), .rd_data_o(rdata), .level_o(level), .full_o(full),
    .empty_o(empty), .overflow_o(ovf), .busy_o(busy), .idle_o(idle), .irq_o(irq)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference state
  logic [14:0] q[$];
  bit running = 0, outstanding = 0, stop_pend = 0, m_ovf = 0, vnow = 0;
  bit run_pre = 0, out_pre = 0, in_rst = 1;
  int idx = 0, exp_req = 0, lat = 0, lat_set = 1, nsamp = 0, sz_pre = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic int dly();
    return (int'(dcnt) + 1) * (1 << (2 * int'(dtb)));
  endfunction

  function automatic logic [2:0] slot(input int i);
    return list[i*3 +: 3];
  endfunction

  task automatic compare_all();
    bit er;
    int sz;
    sz = q.size();
    er = running && !outstanding && (cyc == exp_req);
    chk(req === er, "R3 conv_req_o timing", req, er);
    if (req && er) chk(chan === slot(idx), "R4 conv_chan_o", chan, slot(idx));
    chk(busy[0] === running, "R2 sample busy", busy[0], running);
    chk(busy === {dbusy, abusy, running}, "R11 busy vector", busy, {dbusy, abusy, running});
    chk(idle === !(dbusy || abusy || running), "R11 idle_o", idle, !(dbusy || abusy || running));
    chk(level === 5'(sz % 32), "R7 level_o", level, sz % 32);
    chk(full === (sz == 32), "R7 full_o", full, sz == 32);
    chk(empty === (sz == 0), "R7 empty_o", empty, sz == 0);
    chk(rdata === (sz > 0 ? q[0] : 15'h0), "R6 rd_data_o", rdata, sz > 0 ? q[0] : 15'h0);
    chk(ovf === m_ovf, "R8 overflow_o", ovf, m_ovf);
    chk(irq === (irq_en && sz >= int'(thr)), "R9 irq_o", irq, irq_en && sz >= int'(thr));
  endtask

  task automatic tick();
    logic [11:0] d;
    logic [14:0] ent;
    bit fresh;
    @(negedge clk);
    if (!in_rst) compare_all();
    fresh = 0;
    if (req && !outstanding) begin
      outstanding = 1;
      lat = lat_set;
      fresh = 1;
    end
    sz_pre = q.size();
    run_pre = running;
    out_pre = outstanding;
    start = 0; stop = 0; rd = 0; cvalid = 0; vnow = 0;
    if (outstanding && !fresh) begin
      lat--;
      if (lat == 0) begin
        d = 12'hC00 | 12'((nsamp * 12'h137) & 12'h3FF);
        if (nsamp % 3 == 1) d = d & 12'h7FF;
        nsamp++;
        cvalid = 1;
        cdata = d;
        vnow = 1;
        ent = {slot(idx), wide ? d : (d & 12'h3FF)};
        if (sz_pre < 32) q.push_back(ent);
        else m_ovf = 1;
        outstanding = 0;
        if (stop_pend || (idx == int'(max_idx) && !cont)) begin
          running = 0;
          stop_pend = 0;
        end else begin
          idx = (idx == int'(max_idx)) ? 0 : idx + 1;
          exp_req = cyc + 1 + dly();
        end
      end
    end
  endtask

  task automatic do_start();
    start = 1;
    if (en && !run_pre) begin
      running = 1;
      idx = 0;
      stop_pend = 0;
      exp_req = cyc + 1 + dly();
    end
  endtask

  task automatic do_stop();
    stop = 1;
    if (run_pre) begin
      if (vnow) begin
        running = 0;
        stop_pend = 0;
      end else if (out_pre) stop_pend = 1;
      else running = 0;
    end
  endtask

  task automatic do_rd();
    rd = 1;
    if (sz_pre > 0) void'(q.pop_front());
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && running; k++) tick();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int sz;
    run(3);
    rst_n = 1;
    in_rst = 0;
    tick();
    // R1 reset state
    chk(req === 0 && busy === 0 && idle === 1, "R1 idle after reset", {req, busy}, 0);
    chk(empty === 1 && full === 0 && level === 0, "R1 queue empty after reset", {empty, full, level}, 7'h40);
    chk(ovf === 0 && irq === 0, "R1 flags after reset", {ovf, irq}, 0);

    // R2: start without enable ignored
    list = 24'o01234567; max_idx = 3'd2; dcnt = 8'd2; dtb = 2'd1; wide = 1;
    do_start();
    run(20);
    chk(busy[0] === 0, "R2 start without enable", busy[0], 0);

    // single pass over three slots, plus a start while busy
    en = 1; lat_set = 2;
    tick(); do_start();
    run(3); do_start();
    wait_idle(); tick();
    chk(q.size() == 3 && busy[0] === 0, "R5 single pass ends idle", q.size(), 3);
    chk(rdata[14:12] === 3'd7, "R4 slot 0 channel", rdata[14:12], 7);
    for (int i = 0; i < 4; i++) begin do_rd(); tick(); end
    chk(rdata === 15'h0 && empty === 1, "R7 empty read returns zero", rdata, 0);

    // single slot, narrow samples, minimal delay
    max_idx = 3'd0; dcnt = 8'd0; dtb = 2'd0; wide = 0; lat_set = 1;
    do_start(); wait_idle(); tick();
    chk(q.size() == 1, "R4 max index zero uses one slot", q.size(), 1);
    chk(rdata[11:10] === 2'b00, "R6 narrow mask", rdata[11:10], 0);
    do_rd(); tick();

    // continuous run to overflow, interrupt, side busy flags
    wide = 1; max_idx = 3'd7; dcnt = 8'd1; cont = 1; irq_en = 1; thr = 5'd4;
    do_start();
    for (int k = 0; k < 3000 && !m_ovf; k++) begin
      if (k == 40) abusy = 1;
      if (k == 45) dbusy = 1;
      if (k == 50) begin abusy = 0; dbusy = 0; end
      tick();
    end
    run(12);
    chk(ovf === 1 && full === 1, "R8 overflow on full", {ovf, full}, 3);
    chk(busy[0] === 1, "R5 continuous keeps running", busy[0], 1);
    do_stop(); wait_idle(); tick();
    chk(busy[0] === 0, "R10 stop ends continuous run", busy[0], 0);
    sz = q.size();
    cvalid = 1; cdata = 12'h123;
    tick(); tick();
    chk(q.size() == sz && level === 5'(sz % 32), "R12 stray valid ignored", level, sz % 32);
    for (int i = 0; i < 33; i++) begin do_rd(); tick(); end
    chk(empty === 1 && irq === 0 && ovf === 1, "R8 overflow stays after drain", {empty, irq, ovf}, 3'b101);

    // stop during settle
    cont = 0; max_idx = 3'd0; dcnt = 8'd20; dtb = 2'd1;
    do_start(); run(10);
    do_stop(); tick(); tick();
    chk(busy[0] === 0, "R10 stop in settle", busy[0], 0);
    run(100);
    chk(q.size() == 0 && empty === 1, "R10 no result after settle stop", q.size(), 0);

    // stop with conversion outstanding
    max_idx = 3'd3; dcnt = 8'd0; dtb = 2'd0; cont = 1; lat_set = 5;
    do_start();
    for (int k = 0; k < 200 && !outstanding; k++) tick();
    do_stop(); wait_idle(); tick();
    chk(q.size() == 1 && level === 5'd1 && busy[0] === 0, "R10 outstanding result kept", level, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule